// File: doc/BRIEF.md
# Interrupt Moderation Delay Controller

This block drives a network controller's single interrupt pin from the pending interrupt causes. A cause is pending when its bit is set in both the cause vector and the mask. Each time the pin rises, the block opens a hold-off window. While that window is open, a new rising edge is held back until the window closes. Falling edges always pass straight through.

The window length is worked out again at every rise. It is the smallest non-zero value among three candidates: a transmit absolute delay, a receive absolute delay and a general throttle interval. Each candidate is enabled by its own condition. The transmit candidate is also enabled by a sticky flag, which is set by a per-descriptor delay-request strobe. The window is counted in 256 ns ticks, which come from a clock prescaler.

A small write/read port gives access to the four delay registers. A global enable input can switch moderation off, and then the pin follows the pending set directly.

Top module: `irq_moderator`

## Requirements
- R1: The pending set is `mask_i & cause_i`. `irq_o` is a registered level. It is never high in the cycle after one in which the pending set was zero.
- R2: A rising edge occurs when `irq_o` is low and the pending set is non-zero. With moderation on and no window running, a rising edge sets `irq_o` at the next clock edge. On that same edge the window is armed with the selected delay. A selected delay of zero arms no window.
- R3: While a window runs, a rising edge is deferred and `irq_o` stays low. After the window ends, `irq_o` rises on the next clock edge if the pending set is still non-zero, and that rise arms a new window.
- R4: A window armed with delay D lasts exactly D*TICK_DIV clock cycles from the arming edge. The prescaler restarts when the window is armed.
- R5: The transmit candidate is 4 times the transmit absolute delay register. It is used only when the sticky delay-request flag is set and cause bit 0 (transmit descriptor written) or cause bit 1 (transmit queue empty) is pending.
- R6: The receive candidate is 4 times the receive absolute delay register. It is used only when the receive timer register is non-zero and cause bit 7 (receive timer) is pending.
- R7: The throttle register is always a candidate. The selected delay is the smallest non-zero enabled candidate. Zero candidates are ignored.
- R8: The sticky delay-request flag is the OR of all `desc_ide_i` strobes. Every delay computation clears it. A strobe that arrives in the same cycle as a computation is kept.
- R9: The registers sit at these addresses: 0 transmit absolute delay, 1 receive absolute delay, 2 receive timer, 3 throttle. Each register keeps the lower 16 bits of a write, and bits 31:16 read back as zero.
- R10: With `mit_en_i` low, `irq_o` follows whether the pending set is non-zero, one cycle later. Any running window is dropped.
- R11: Reset sets `irq_o` low, clears all four registers, stops the window and clears the sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mit_en_i | input | 1 | Moderation enable |
| cause_i | input | CAUSE_W | Interrupt cause vector |
| mask_i | input | CAUSE_W | Interrupt mask |
| desc_ide_i | input | 1 | Strobe: a processed transmit descriptor requested delay |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Interrupt pin level |

## Verification
The assertions check these properties on every cycle:
- the pin is never high right after a cycle with nothing pending;
- the pin stays low throughout a running window;
- the pin follows the pending set when moderation is off;
- the idle timer holds zero;
- arming with a non-zero delay starts the window;
- the sticky flag clears after each computation.

Some behaviour can only be shown by the bench's scenarios:
- the exact cycle at which a deferred edge comes out;
- which candidate wins for a given mix of causes, register values and strobes;
- how register writes are truncated.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
  localparam int REG_W  = 16;
  localparam int N_SRC  = 3;
  localparam int DLY_W  = REG_W + 2;

  typedef enum logic [1:0] {
    ADDR_TX_ABS   = 2'd0,
    ADDR_RX_ABS   = 2'd1,
    ADDR_RX_TMR   = 2'd2,
    ADDR_THROTTLE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [REG_W-1:0] tx_abs;
    logic [REG_W-1:0] rx_abs;
    logic [REG_W-1:0] rx_tmr;
    logic [REG_W-1:0] thr;
  } dly_regs_t;

  typedef enum int {
    SRC_TX  = 0,
    SRC_RX  = 1,
    SRC_THR = 2
  } src_e;
endpackage

// File: rtl/irqmod_regs.sv
module irqmod_regs
  import irqmod_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output dly_regs_t         regs_o
);
  localparam int N_REG = 4;

  logic [REG_W-1:0] r_q [N_REG];

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          r_q[i] <= '0;
      else if (we_i && addr_i == 2'(i))     r_q[i] <= wdata_i[REG_W-1:0];
    end
  end

  assign rdata_o = DATA_W'(r_q[addr_i]);

  assign regs_o.tx_abs = r_q[ADDR_TX_ABS];
  assign regs_o.rx_abs = r_q[ADDR_RX_ABS];
  assign regs_o.rx_tmr = r_q[ADDR_RX_TMR];
  assign regs_o.thr    = r_q[ADDR_THROTTLE];

  // R9: upper read bits never set
  assert_rd_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:REG_W] == '0);
endmodule

// File: rtl/irqmod_delay_sel.sv
module irqmod_delay_sel
  import irqmod_pkg::*;
(
  input  logic [N_SRC-1:0][DLY_W-1:0] cand_i,
  input  logic [N_SRC-1:0]            en_i,
  output logic [DLY_W-1:0]            dly_o
);
  logic [N_SRC-1:0][DLY_W-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_gate
    assign gated[i] = en_i[i] ? cand_i[i] : '0;
  end

  // smallest non-zero; zero means "not set"
  always_comb begin
    dly_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (gated[i] != '0 && (dly_o == '0 || gated[i] < dly_o)) dly_o = gated[i];
    end
  end
endmodule

// File: rtl/irqmod_timer.sv
module irqmod_timer #(
  parameter int TICK_DIV = 64,
  parameter int CNT_W    = 24,
  parameter int DLY_W    = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             running_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

  logic [PW-1:0]    presc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             tick;

  assign tick = (presc_q == PLAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else if (clr_i) begin
      presc_q <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else if (load_i) begin
      presc_q <= '0;
      cnt_q   <= CNT_W'(dly_i);
      run_q   <= (dly_i != '0);
    end else if (run_q) begin
      if (tick) begin
        presc_q <= '0;
        cnt_q   <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  assign running_o = run_q;

  assert_idle_cnt_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> cnt_q == '0);
  assert_load_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && dly_i != '0) |=> run_q);
  assert_cnt_hold_between_ticks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !load_i && !clr_i && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irqmod_pkg::*;
#(
  parameter int CAUSE_W  = 32,
  parameter int DATA_W   = 32,
  parameter int TICK_DIV = 64,
  parameter int CNT_W    = 24,
  parameter int TXDW_BIT = 0,
  parameter int TXQE_BIT = 1,
  parameter int RXT_BIT  = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mit_en_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CAUSE_W-1:0] mask_i,
  input  logic               desc_ide_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  dly_regs_t                   regs;
  logic [CAUSE_W-1:0]          pending;
  logic                        any_pend;
  logic                        level_q, level_d;
  logic                        ide_q;
  logic                        running;
  logic                        rise;
  logic                        compute;
  logic [N_SRC-1:0][DLY_W-1:0] cand;
  logic [N_SRC-1:0]            cand_en;
  logic [DLY_W-1:0]            sel_dly;

  assign pending  = mask_i & cause_i;
  assign any_pend = |pending;
  assign rise     = !level_q && any_pend;
  assign compute  = mit_en_i && rise && !running;

  irqmod_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .regs_o  (regs)
  );

  // absolute delays are in 4x ticks
  assign cand[SRC_TX]     = {regs.tx_abs, 2'b00};
  assign cand[SRC_RX]     = {regs.rx_abs, 2'b00};
  assign cand[SRC_THR]    = DLY_W'(regs.thr);
  assign cand_en[SRC_TX]  = ide_q && (pending[TXDW_BIT] || pending[TXQE_BIT]);
  assign cand_en[SRC_RX]  = (regs.rx_tmr != '0) && pending[RXT_BIT];
  assign cand_en[SRC_THR] = 1'b1;

  irqmod_delay_sel u_sel (
    .cand_i (cand),
    .en_i   (cand_en),
    .dly_o  (sel_dly)
  );

  irqmod_timer #(
    .TICK_DIV (TICK_DIV),
    .CNT_W    (CNT_W),
    .DLY_W    (DLY_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!mit_en_i),
    .load_i    (compute),
    .dly_i     (sel_dly),
    .running_o (running)
  );

  // deferred edge: hold low while window runs
  always_comb begin
    level_d = any_pend;
    if (mit_en_i && rise && running) level_d = level_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      ide_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      ide_q   <= compute ? desc_ide_i : (ide_q || desc_ide_i);
    end
  end

  assign irq_o = level_q;

  assert_masked_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_pend |=> !irq_o);
  assert_hold_in_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mit_en_i && running && !irq_o) |=> !irq_o);
  assert_bypass_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mit_en_i |=> irq_o == $past(any_pend));
  assert_sticky_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (compute && !desc_ide_i) |=> !ide_q);
  assert_idle_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compute |=> irq_o);
endmodule

// File: tb/irq_moderator_test.sv
module irq_moderator_test;
  localparam int CW  = 32;
  localparam int DW  = 32;
  localparam int DIV = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mit_en_i = 1'b1;
  logic [CW-1:0] cause_i = '0;
  logic [CW-1:0] mask_i = '0;
  logic          desc_ide_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_addr_i = '0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic          irq_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  int    exp_cyc_q[$];
  string exp_tag_q[$];
  logic  prev_irq = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  irq_moderator #(.CAUSE_W(CW), .DATA_W(DW), .TICK_DIV(DIV)) uut (
    .clk_i, .rst_ni, .mit_en_i, .cause_i, .mask_i, .desc_ide_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: every rising irq_o must match the next scoreboard entry
  always @(negedge clk_i) begin
    if (rst_ni && irq_o && !prev_irq) begin
      checks++;
      if (exp_cyc_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected rise at cyc %0d (actual rise, expected none)", cyc);
      end else begin
        int e;
        string t;
        e = exp_cyc_q.pop_front();
        t = exp_tag_q.pop_front();
        if (e != cyc) begin
          failures++;
          $display("FAIL %s rise cyc actual=%0d expected=%0d", t, cyc, e);
        end
      end
    end
    prev_irq = irq_o;
  end

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [DW-1:0] e, input string tag);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(reg_rdata_o, e, tag);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 400 && exp_cyc_q.size() != 0; i++) @(negedge clk_i);
    checks++;
    if (exp_cyc_q.size() != 0) begin
      failures++;
      $display("FAIL %s missing rise actual=none expected=%0d", tag, exp_cyc_q[0]);
      exp_cyc_q.delete(); exp_tag_q.delete();
    end
  endtask

  // raise, drop, raise again; d = expected window in ticks (0: none)
  task automatic probe(input logic [CW-1:0] cv, input int d, input string tag);
    int c;
    @(negedge clk_i);
    c = cyc; cause_i = cv;
    exp_cyc_q.push_back(c + 1); exp_tag_q.push_back({tag, " first"});
    @(negedge clk_i);
    cause_i = '0;
    @(negedge clk_i);
    cause_i = cv;
    exp_cyc_q.push_back((d == 0 || !mit_en_i) ? c + 3 : c + 2 + d * DIV);
    exp_tag_q.push_back({tag, " second"});
    drain(tag);
    cause_i = '0;
    repeat (80) @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk(DW'(irq_o), 0, "R11 irq after reset");
    rst_ni = 1'b1;
    rd_chk(2'd0, 0, "R11 tx reg reset");
    rd_chk(2'd1, 0, "R11 rx reg reset");
    rd_chk(2'd2, 0, "R11 rx timer reset");
    rd_chk(2'd3, 0, "R11 throttle reset");

    // R9: truncation to 16 bits
    wr(2'd3, 32'hFFFF_1234);
    rd_chk(2'd3, 32'h0000_1234, "R9 throttle truncate");
    wr(2'd0, 32'hABCD_0005);
    rd_chk(2'd0, 32'h0000_0005, "R9 tx truncate");
    wr(2'd3, 3);
    wr(2'd0, 0);

    // R1: masked cause never raises the pin
    @(negedge clk_i); cause_i = 32'h1;
    repeat (10) @(negedge clk_i);
    chk(DW'(irq_o), 0, "R1 masked cause");
    mask_i = '1;
    exp_cyc_q.push_back(cyc + 1); exp_tag_q.push_back("R1 R2 unmask rise");
    drain("R1 unmask");
    cause_i = '0;
    repeat (40) @(negedge clk_i);

    // R3 R4 R7: throttle-only window of 3 ticks
    probe(32'h1, 3, "R3 R4 R7 throttle 3");

    // R2: zero delay arms nothing
    wr(2'd3, 0);
    probe(32'h1, 0, "R2 zero delay");

    // R6: receive candidate 4*1 beats throttle 10 when enabled
    wr(2'd3, 10);
    wr(2'd1, 1);
    wr(2'd2, 1);
    probe(32'h80, 4, "R6 rx enabled");
    wr(2'd2, 0);
    probe(32'h80, 10, "R6 rx timer zero");
    wr(2'd2, 1);
    probe(32'h1, 10, "R6 rx cause absent");

    // R5 R8: transmit candidate needs sticky request
    wr(2'd0, 1);
    @(negedge clk_i); desc_ide_i = 1'b1;
    @(negedge clk_i); desc_ide_i = 1'b0;
    probe(32'h1, 4, "R5 R8 tx desc written");
    probe(32'h1, 10, "R8 sticky cleared");
    @(negedge clk_i); desc_ide_i = 1'b1;
    @(negedge clk_i); desc_ide_i = 1'b0;
    probe(32'h2, 4, "R5 tx queue empty");

    // R7: throttle smaller than absolute delays
    wr(2'd3, 2);
    probe(32'h80, 2, "R7 min throttle");

    // R10: moderation off follows pending
    @(negedge clk_i); mit_en_i = 1'b0;
    probe(32'h1, 0, "R10 bypass");
    @(negedge clk_i); cause_i = 32'h1;
    @(negedge clk_i);
    chk(DW'(irq_o), 1, "R10 level high");
    exp_cyc_q.push_back(cyc); exp_tag_q.push_back("R10 level");
    cause_i = '0;
    @(negedge clk_i);
    chk(DW'(irq_o), 0, "R10 level low");
    mit_en_i = 1'b1;
    repeat (20) @(negedge clk_i);

    chk(exp_cyc_q.size(), 0, "scoreboard empty");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule